// File: doc/BRIEF.md
# 80-bit Key Round-Key Generator

This block expands an 80-bit secret key into a sequence of 36 round keys of 32 bits each, one key per advance request, for a lightweight 64-bit block cipher data path. The working key is held as twenty 4-bit nibbles, numbered 0 to 19 with nibble 0 at the most significant end of the key. Each round key is formed by picking eight fixed nibbles out of that register.

A load pulse captures a new key and presents round key 1 on the next cycle. Each advance pulse then updates the working register. The update passes two nibbles through the cipher's 4-bit S-box and folds them into two others. It XORs a 6-bit round constant, split into two 3-bit halves, into two more nibbles. It then rotates the register by four nibbles, with the four wrapped nibbles put back in a new order. Advancing past round 36 freezes the output and raises a done flag. A new load restarts the whole sequence.

Top module: `keysched80`

## Requirements
- R1: While rst_n is low, and on the first cycle after reset, rk_valid_o and done_o are 0 and rk_o is 0.
- R2: On the cycle after load_i is high, rk_valid_o is 1, done_o is 0, and rk_o is round key 1. Round key 1 is taken directly from key_i. With nibble n = key_i[79-4n -: 4], rk_o holds nibbles 1, 3, 4, 6, 13, 14, 15, 16 from bit 31 downward.
- R3: Each step_i pulse with rk_valid_o=1 and done_o=0 updates the working register; rk_o then shows the next round key taken from the same nibble positions. The update runs in this order. First, nibble 1 ^= S(nibble 0) and nibble 4 ^= S(nibble 16). The S-box maps 0..F to C,0,F,A,2,B,9,5,8,3,D,7,1,E,6,4. Next, nibble 7 ^= {0, con[5:3]} and nibble 19 ^= {0, con[2:0]}. Last, new nibble n = nibble n+4 for n=0..15, and new nibbles 16..19 = the post-XOR nibbles 1, 2, 3, 0.
- R4: The constant con is 01 for the first update after a load. After each update it is multiplied by x in GF(2^6) with polynomial x^6+x+1, so it runs 01,02,04,08,10,20,03,06,...
- R5: After 35 updates rk_o shows round key 36. The next step_i sets done_o. Further step_i pulses leave rk_o unchanged and done_o set.
- R6: step_i before any load has no effect: rk_valid_o stays 0, done_o stays 0 and rk_o stays 0.
- R7: A load during a run or after done restarts the sequence. It clears done_o, shows round key 1 of the new key, and resets the constant to 01.
- R8: When load_i and step_i are high in the same cycle, the load takes effect and the step is dropped.
- R9: With load_i and step_i both low, rk_o, rk_valid_o and done_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture key_i and restart at round 1 |
| key_i | input | 80 | Secret key, nibble 0 at bits 79:76 |
| step_i | input | 1 | Advance to the next round key |
| rk_o | output | 32 | Current round key |
| rk_valid_o | output | 1 | A key has been loaded |
| done_o | output | 1 | An advance was requested past round 36 |

## Verification
The hardest state to reach from the ports is the end of the schedule. Reaching it takes a full run of 35 updates from a load, and only the 36th step sets the done flag and freezes the output. The bench drives several keys through the complete run, comparing every round key with an independent model. It then steps past the end, reloads mid-run, and reloads after done, to show that the constant restarts at 01.

// File: rtl/ks80_pkg.sv
package ks80_pkg;
    localparam int NIB_W   = 4;
    localparam int NIB_CNT = 20;
    localparam int KEY_W   = NIB_W * NIB_CNT;
    localparam int RK_NIBS = 8;
    localparam int RK_W    = RK_NIBS * NIB_W;
    localparam int ROUNDS  = 36;
    localparam int RND_W   = $clog2(ROUNDS + 1);
    localparam int CON_W   = 6;
    localparam int CON_HW  = CON_W / 2;
    localparam int ROT     = 4;
    localparam logic [CON_W-1:0] CON_SEED = 6'h01;
    localparam logic [CON_W-1:0] CON_TAPS = 6'h03;   // x^6 = x + 1

    localparam int RK_TAP [RK_NIBS] = '{1, 3, 4, 6, 13, 14, 15, 16};
    localparam int SB_SRC [2]       = '{0, 16};
    localparam int SB_DST [2]       = '{1, 4};
    localparam int WRAP   [ROT]     = '{1, 2, 3, 0};
    localparam int CON_HI_DST       = 7;
    localparam int CON_LO_DST       = 19;

    typedef logic [0:NIB_CNT-1][NIB_W-1:0] wk_t;

    typedef struct packed {
        wk_t              wk;
        logic [CON_W-1:0] con;
        logic [RND_W-1:0] rnd;
        logic             valid;
        logic             exh;
    } ks_state_t;
endpackage

// File: rtl/ks_sbox4.sv
module ks_sbox4 (
    input  logic [3:0] x_i,
    output logic [3:0] y_o
);
    always_comb begin
        case (x_i)
            4'h0: y_o = 4'hC;
            4'h1: y_o = 4'h0;
            4'h2: y_o = 4'hF;
            4'h3: y_o = 4'hA;
            4'h4: y_o = 4'h2;
            4'h5: y_o = 4'hB;
            4'h6: y_o = 4'h9;
            4'h7: y_o = 4'h5;
            4'h8: y_o = 4'h8;
            4'h9: y_o = 4'h3;
            4'hA: y_o = 4'hD;
            4'hB: y_o = 4'h7;
            4'hC: y_o = 4'h1;
            4'hD: y_o = 4'hE;
            4'hE: y_o = 4'h6;
            default: y_o = 4'h4;
        endcase
    end
endmodule

// File: rtl/ks_rcon.sv
module ks_rcon
    import ks80_pkg::*;
(
    input  logic [CON_W-1:0] con_i,
    output logic [CON_W-1:0] con_o
);
    // multiply by x, reduce by the field polynomial
    always_comb begin
        con_o = {con_i[CON_W-2:0], 1'b0};
        if (con_i[CON_W-1]) con_o = con_o ^ CON_TAPS;
    end
endmodule

// File: rtl/ks_update.sv
module ks_update
    import ks80_pkg::*;
(
    input  wk_t              wk_i,
    input  logic [CON_W-1:0] con_i,
    output wk_t              wk_o
);
    logic [NIB_W-1:0] sb_y [2];

    for (genvar g = 0; g < 2; g++) begin : g_sb
        ks_sbox4 u_sb (.x_i(wk_i[SB_SRC[g]]), .y_o(sb_y[g]));
    end

    wk_t mix;

    always_comb begin
        mix = wk_i;
        for (int g = 0; g < 2; g++) begin
            mix[SB_DST[g]] = mix[SB_DST[g]] ^ sb_y[g];
        end
        mix[CON_HI_DST] = mix[CON_HI_DST] ^ {{(NIB_W-CON_HW){1'b0}}, con_i[CON_W-1:CON_HW]};
        mix[CON_LO_DST] = mix[CON_LO_DST] ^ {{(NIB_W-CON_HW){1'b0}}, con_i[CON_HW-1:0]};
        for (int n = 0; n < NIB_CNT - ROT; n++) begin
            wk_o[n] = mix[n + ROT];
        end
        for (int m = 0; m < ROT; m++) begin
            wk_o[NIB_CNT - ROT + m] = mix[WRAP[m]];
        end
    end
endmodule

// File: rtl/keysched80.sv
module keysched80
    import ks80_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             step_i,
    output logic [RK_W-1:0]  rk_o,
    output logic             rk_valid_o,
    output logic             done_o
);
    ks_state_t        st_d, st_q;
    wk_t              wk_upd;
    logic [CON_W-1:0] con_nxt;

    ks_update u_upd (.wk_i(st_q.wk), .con_i(st_q.con), .wk_o(wk_upd));
    ks_rcon   u_con (.con_i(st_q.con), .con_o(con_nxt));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.wk    = wk_t'(key_i);
            st_d.con   = CON_SEED;
            st_d.rnd   = RND_W'(1);
            st_d.valid = 1'b1;
            st_d.exh   = 1'b0;
        end else if (step_i && st_q.valid && !st_q.exh) begin
            if (st_q.rnd < RND_W'(ROUNDS)) begin
                st_d.wk  = wk_upd;
                st_d.con = con_nxt;
                st_d.rnd = st_q.rnd + RND_W'(1);
            end else begin
                st_d.exh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < RK_NIBS; i++) begin : g_rk
        assign rk_o[RK_W-1-NIB_W*i -: NIB_W] = st_q.wk[RK_TAP[i]];
    end

    assign rk_valid_o = st_q.valid;
    assign done_o     = st_q.exh;
endmodule

// File: rtl/ks80_chk.sv
module ks80_chk
    import ks80_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            load_i,
    input logic            step_i,
    input logic [RK_W-1:0] rk_o,
    input logic            rk_valid_o,
    input logic            done_o
);
    logic [RND_W:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || load_i)                          acc_q <= '0;
        else if (step_i && rk_valid_o && !done_o)      acc_q <= acc_q + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !rk_valid_o && !done_o && rk_o == '0);                        // R1
    AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> rk_valid_o && !done_o);                                       // R2
    AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rk_valid_o |-> !done_o && rk_o == '0);                                  // R6
    AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !load_i |=> done_o && $stable(rk_o));                          // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> acc_q == (RND_W+1)'(ROUNDS));                          // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !step_i |=> $stable(rk_o) && $stable(rk_valid_o) && $stable(done_o)); // R9
endmodule

bind keysched80 ks80_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .rk_o(rk_o), .rk_valid_o(rk_valid_o), .done_o(done_o)
);

// File: tb/sim_keysched80.sv
`timescale 1ns/1ps
module sim_keysched80;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [79:0] key_i = '0;
    logic        step_i = 1'b0;
    logic [31:0] rk_o;
    logic        rk_valid_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    keysched80 u0 (.*);

    localparam logic [63:0] SBT = 64'hC0FA2B95_83D71E64;
    localparam int NKEYS = 4;
    localparam logic [79:0] KEYS [NKEYS] = '{
        80'h00112233445566778899,
        80'h0,
        80'hFFFFFFFFFFFFFFFFFFFF,
        80'h3C5A_9E01_B7D2_468F_E013
    };

    function automatic logic [3:0] sb(input logic [3:0] x);
        return SBT[63-4*x -: 4];
    endfunction

    function automatic logic [31:0] m_rk(input logic [79:0] k);
        return {k[75:72], k[67:64], k[63:60], k[55:52],
                k[27:24], k[23:20], k[19:16], k[15:12]};
    endfunction

    function automatic logic [79:0] m_step(input logic [79:0] k, input logic [5:0] c);
        logic [3:0] w [20];
        logic [79:0] r;
        for (int n = 0; n < 20; n++) w[n] = k[79-4*n -: 4];
        w[1]  = w[1] ^ sb(w[0]);
        w[4]  = w[4] ^ sb(w[16]);
        w[7]  = w[7] ^ {1'b0, c[5:3]};
        w[19] = w[19] ^ {1'b0, c[2:0]};
        for (int n = 0; n < 16; n++) r[79-4*n -: 4] = w[n+4];
        r[15:12] = w[1];
        r[11:8]  = w[2];
        r[7:4]   = w[3];
        r[3:0]   = w[0];
        return r;
    endfunction

    function automatic logic [5:0] m_con(input logic [5:0] c);
        logic [6:0] p;
        p = {c, 1'b0};
        if (p[6]) p = p ^ 7'b1000011;
        return p[5:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic [79:0] k, input logic with_step);
        @(negedge clk);
        key_i = k; load_i = 1'b1; step_i = with_step;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [79:0] mk;
        logic [5:0]  mc;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'b0, rk_valid_o}, 32'd0);
        chk("R1 done in reset", {31'b0, done_o}, 32'd0);
        chk("R1 rk in reset", rk_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rk after reset", rk_o, 32'd0);

        // R6: step before any load
        do_step();
        chk("R6 valid", {31'b0, rk_valid_o}, 32'd0);
        chk("R6 done", {31'b0, done_o}, 32'd0);
        chk("R6 rk", rk_o, 32'd0);

        // full runs for every key in the table
        for (int v = 0; v < NKEYS; v++) begin
            mk = KEYS[v]; mc = 6'h01;
            do_load(mk, 1'b0);
            chk("R2 valid", {31'b0, rk_valid_o}, 32'd1);
            chk("R2 round1", rk_o, m_rk(mk));
            for (int r = 2; r <= 36; r++) begin
                mk = m_step(mk, mc); mc = m_con(mc);
                do_step();
                chk("R3 R4 round key", rk_o, m_rk(mk));
                chk("R5 not done yet", {31'b0, done_o}, 32'd0);
            end
            do_step();
            chk("R5 done set", {31'b0, done_o}, 32'd1);
            chk("R5 rk frozen", rk_o, m_rk(mk));
            do_step();
            chk("R5 rk still frozen", rk_o, m_rk(mk));
        end

        // R9: idle cycles hold outputs
        repeat (5) @(negedge clk);
        chk("R9 rk hold", rk_o, m_rk(mk));
        chk("R9 done hold", {31'b0, done_o}, 32'd1);

        // R7: reload after done restarts with constant 01
        do_load(KEYS[3], 1'b0);
        chk("R7 done cleared", {31'b0, done_o}, 32'd0);
        chk("R7 round1", rk_o, m_rk(KEYS[3]));
        do_step(); do_step(); do_step();
        mk = m_step(m_step(m_step(KEYS[3], 6'h01), 6'h02), 6'h04);
        chk("R4 third update", rk_o, m_rk(mk));

        // R7: reload mid-run
        do_load(KEYS[0], 1'b0);
        chk("R7 mid-run round1", rk_o, m_rk(KEYS[0]));
        do_step();
        chk("R7 constant restarted", rk_o, m_rk(m_step(KEYS[0], 6'h01)));

        // R8: load and step together
        do_load(KEYS[2], 1'b1);
        chk("R8 load wins", rk_o, m_rk(KEYS[2]));
        do_step();
        chk("R8 first step after", rk_o, m_rk(m_step(KEYS[2], 6'h01)));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule